// File: doc/BRIEF.md
# PHY Management Status Register File

This block holds the management-visible registers of a 10/100 Ethernet PHY: the basic status word, two fixed identifier words, the auto-negotiation advertisement word, the captured link-partner code word and the auto-negotiation expansion word. A parallel register port carries a 5-bit address, write and read strobes, and 16-bit write and read data. The serial management framing, the control register and the auto-negotiation engine sit outside the block.

Line-side event inputs feed sticky status bits. Remote fault, jabber (10 Mb/s only), page received and parallel detection fault are held until software reads the register that holds them. The link bit is latch-low: a link drop stays visible until software reads it. Advertisement technology bits can only be set where the PHY has the matching ability. A change written to the advertisement word reaches the auto-negotiation engine only when a restart strobe arrives.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Status (address 1) reads bit 15 = 0, bits 14:11 = ABILITY parameter (bit 14 100 Mb/s full, 13 100 Mb/s half, 12 10 Mb/s full, 11 10 Mb/s half; default 4'b1111), bits 10:6 = 0, bit 0 = 1, bit 3 = an_enable_i, bit 5 = an_complete_i. Writes do not change it.
- R2: Status bit 4 sets when rfault_i is high at a clock edge and clears only when the status register is read.
- R3: Status bit 2 reads link_ok_i unless the link has fallen since the last status read; in that case it reads 0 for that one read, even if the link is back up.
- R4: Status bit 1 sets when jabber_i and speed_10_i are both high. jabber_i is ignored while speed_10_i is low. The bit holds until a status read.
- R5: Address 2 reads 16'h000E. Address 3 reads 16'h7237: OUI low bits 6'h1C in 15:10, model 6'h23 in 9:4, revision 4'h7 in 3:0.
- R6: Advertisement (address 4) resets to {7'b0, ABILITY, 5'b00001}. Bits 13 and 11 are read/write with reset 0. Bits 8:5 are writable, but a written 1 is forced to 0 where the matching ABILITY bit is 0. Bits 15, 14, 12, 10 and 9 read 0, and bits 4:0 read 5'b00001.
- R7: adv_word_o changes only on an_restart_i, when it takes the stored advertisement value from before any write in that same cycle.
- R8: Address 5 holds lp_word_i captured on lp_valid_i and is read-only.
- R9: Expansion (address 6) bit 1 sets on lp_valid_i and bit 4 sets on pd_fault_i. Both clear when address 6 is read. All other bits read 0.
- R10: If a sticky bit is set in the same cycle as a read of its register, the read returns the old value and the bit ends up set.
- R11: Addresses other than 1 to 6 read 16'h0000. Writes to any address other than 4 have no effect.
- R12: rdata_o is loaded at the clock edge that samples rd_en_i high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| link_ok_i | input | 1 | Line link is good |
| jabber_i | input | 1 | Jabber event |
| speed_10_i | input | 1 | PHY is in 10 Mb/s mode |
| rfault_i | input | 1 | Remote fault detected |
| an_enable_i | input | 1 | Auto-negotiation enabled (from control) |
| an_complete_i | input | 1 | Auto-negotiation complete |
| an_restart_i | input | 1 | Auto-negotiation restart strobe |
| lp_word_i | input | 16 | Received link-partner code word |
| lp_valid_i | input | 1 | lp_word_i is valid |
| pd_fault_i | input | 1 | Parallel detection fault event |
| adv_word_o | output | 16 | Advertisement word used by auto-negotiation |

## Verification
Two pairs of functions can fall in the same cycle. A sticky-bit set can coincide with the clearing read of its register. An advertisement write can coincide with a restart strobe. The bench raises rfault_i or lp_valid_i on the same edge as a read of status or expansion. It expects that read to show the bit clear and the next read to show it set. It also writes the advertisement register on the edge of a restart strobe, and expects adv_word_o to carry the value from before the write while a readback shows the new one.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 16;
  localparam int unsigned NTECH = 4;

  localparam logic [AW-1:0] ADDR_STATUS = 5'd1;
  localparam logic [AW-1:0] ADDR_ID1    = 5'd2;
  localparam logic [AW-1:0] ADDR_ID2    = 5'd3;
  localparam logic [AW-1:0] ADDR_ADV    = 5'd4;
  localparam logic [AW-1:0] ADDR_LP     = 5'd5;
  localparam logic [AW-1:0] ADDR_EXP    = 5'd6;

  localparam logic [15:0] ID1_VAL  = 16'h000E;
  localparam logic [5:0]  OUI_LO   = 6'h1C;
  localparam logic [5:0]  MODEL_NO = 6'h23;
  localparam logic [3:0]  REV_NO   = 4'h7;
  localparam logic [15:0] ID2_VAL  = {OUI_LO, MODEL_NO, REV_NO};
  localparam logic [4:0]  SELECTOR = 5'b00001;
endpackage

// File: rtl/phy_sticky.sv
module phy_sticky #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set wins over a same-cycle clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (clr_i) q_q <= set_i;
    else            q_q <= q_q | set_i;
  end

  assign q_o = q_q;

  assert_set_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  assert_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == $past(set_i)));
endmodule

// File: rtl/phy_status_reg.sv
module phy_status_reg
  import phy_mgmt_pkg::*;
#(
  parameter logic [NTECH-1:0] ABILITY = 4'b1111
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_ok_i,
  input  logic          jabber_i,
  input  logic          speed_10_i,
  input  logic          rfault_i,
  input  logic          an_enable_i,
  input  logic          an_complete_i,
  input  logic          rd_clr_i,
  output logic [DW-1:0] status_o
);
  logic       link_prev_q;
  logic       link_fall;
  logic [2:0] set_vec;
  logic [2:0] sticky_q;
  logic       lost_q, rf_q, jab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_prev_q <= 1'b0;
    else         link_prev_q <= link_ok_i;
  end

  assign link_fall = link_prev_q & ~link_ok_i;
  assign set_vec   = {link_fall, rfault_i, jabber_i & speed_10_i};

  phy_sticky #(.W(3)) i_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (rd_clr_i),
    .q_o    (sticky_q)
  );

  assign {lost_q, rf_q, jab_q} = sticky_q;

  assign status_o = {1'b0, ABILITY, 5'b00000, an_complete_i, rf_q,
                     an_enable_i, link_ok_i & ~lost_q, jab_q, 1'b1};

  assert_link_latch_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fall |=> !status_o[2]);

  assert_jabber_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!speed_10_i && !jab_q) |=> !status_o[1]);
endmodule

// File: rtl/phy_an_regs.sv
module phy_an_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [NTECH-1:0] ABILITY = 4'b1111
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_adv_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          an_restart_i,
  input  logic [DW-1:0] lp_word_i,
  input  logic          lp_valid_i,
  input  logic          pd_fault_i,
  input  logic          rd_exp_i,
  output logic [DW-1:0] adv_o,
  output logic [DW-1:0] adv_word_o,
  output logic [DW-1:0] lp_o,
  output logic [DW-1:0] exp_o
);
  localparam logic [DW-1:0] ADV_RESET = {7'b0, ABILITY, SELECTOR};

  logic             rf_q, asym_q;
  logic [NTECH-1:0] tech_q;
  logic [DW-1:0]    adv_word_q;
  logic [DW-1:0]    lp_q;
  logic [1:0]       exp_sticky;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_q   <= 1'b0;
      asym_q <= 1'b0;
      tech_q <= ABILITY;
    end else if (wr_adv_i) begin
      rf_q   <= wdata_i[13];
      asym_q <= wdata_i[11];
      tech_q <= wdata_i[8:5] & ABILITY;
    end
  end

  assign adv_o = {2'b00, rf_q, 1'b0, asym_q, 2'b00, tech_q, SELECTOR};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           adv_word_q <= ADV_RESET;
    else if (an_restart_i) adv_word_q <= adv_o;
  end

  assign adv_word_o = adv_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lp_q <= '0;
    else if (lp_valid_i) lp_q <= lp_word_i;
  end

  assign lp_o = lp_q;

  phy_sticky #(.W(2)) i_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({pd_fault_i, lp_valid_i}),
    .clr_i  (rd_exp_i),
    .q_o    (exp_sticky)
  );

  assign exp_o = {11'b0, exp_sticky[1], 2'b00, exp_sticky[0], 1'b0};

  assert_adv_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_adv_i |=> ((adv_o[8:5] & ~ABILITY) == '0));

  assert_adv_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_restart_i |=> $stable(adv_word_o));

  assert_lp_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_valid_i |=> (lp_o == $past(lp_word_i)));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [3:0] ABILITY = 4'b1111
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  addr_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        link_ok_i,
  input  logic        jabber_i,
  input  logic        speed_10_i,
  input  logic        rfault_i,
  input  logic        an_enable_i,
  input  logic        an_complete_i,
  input  logic        an_restart_i,
  input  logic [15:0] lp_word_i,
  input  logic        lp_valid_i,
  input  logic        pd_fault_i,
  output logic [15:0] adv_word_o
);
  logic [DW-1:0] status_w, adv_w, lp_w, exp_w;
  logic [DW-1:0] rd_mux;
  logic          mapped;
  logic [DW-1:0] rdata_q;

  phy_status_reg #(.ABILITY(ABILITY)) i_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .link_ok_i     (link_ok_i),
    .jabber_i      (jabber_i),
    .speed_10_i    (speed_10_i),
    .rfault_i      (rfault_i),
    .an_enable_i   (an_enable_i),
    .an_complete_i (an_complete_i),
    .rd_clr_i      (rd_en_i && addr_i == ADDR_STATUS),
    .status_o      (status_w)
  );

  phy_an_regs #(.ABILITY(ABILITY)) i_an (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_adv_i     (wr_en_i && addr_i == ADDR_ADV),
    .wdata_i      (wdata_i),
    .an_restart_i (an_restart_i),
    .lp_word_i    (lp_word_i),
    .lp_valid_i   (lp_valid_i),
    .pd_fault_i   (pd_fault_i),
    .rd_exp_i     (rd_en_i && addr_i == ADDR_EXP),
    .adv_o        (adv_w),
    .adv_word_o   (adv_word_o),
    .lp_o         (lp_w),
    .exp_o        (exp_w)
  );

  always_comb begin
    mapped = 1'b1;
    unique case (addr_i)
      ADDR_STATUS: rd_mux = status_w;
      ADDR_ID1:    rd_mux = ID1_VAL;
      ADDR_ID2:    rd_mux = ID2_VAL;
      ADDR_ADV:    rd_mux = adv_w;
      ADDR_LP:     rd_mux = lp_w;
      ADDR_EXP:    rd_mux = exp_w;
      default: begin
        rd_mux = '0;
        mapped = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !mapped) |=> (rdata_o == '0));

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  assert_id_const_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_ID2) |=> (rdata_o == 16'h7237));
endmodule

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  localparam logic [3:0] ABIL = 4'b1110;
  localparam logic [15:0] ST_BASE = {1'b0, ABIL, 11'b000_0000_0001};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        link_ok = 0, jabber = 0, speed_10 = 0, rfault = 0;
  logic        an_en = 0, an_comp = 0, an_restart = 0;
  logic [15:0] lp_word = '0;
  logic        lp_valid = 0, pd_fault = 0;
  logic [15:0] adv_word;

  int errors = 0;
  int checks = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  phy_mgmt_regs #(.ABILITY(ABIL)) i_phy_mgmt_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .link_ok_i(link_ok), .jabber_i(jabber),
    .speed_10_i(speed_10), .rfault_i(rfault), .an_enable_i(an_en),
    .an_complete_i(an_comp), .an_restart_i(an_restart), .lp_word_i(lp_word),
    .lp_valid_i(lp_valid), .pd_fault_i(pd_fault), .adv_word_o(adv_word)
  );

  // {is_write, addr, wdata, expected read}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'd2,  16'h0000, 16'h000E},
    {1'b0, 5'd3,  16'h0000, 16'h7237},
    {1'b0, 5'd4,  16'h0000, 16'h01C1},
    {1'b1, 5'd4,  16'hFFFF, 16'h0000},
    {1'b0, 5'd4,  16'h0000, 16'h29C1},
    {1'b1, 5'd4,  16'h0000, 16'h0000},
    {1'b0, 5'd4,  16'h0000, 16'h0001},
    {1'b1, 5'd2,  16'hFFFF, 16'h0000},
    {1'b0, 5'd2,  16'h0000, 16'h000E},
    {1'b0, 5'd0,  16'h0000, 16'h0000},
    {1'b1, 5'd9,  16'hFFFF, 16'h0000},
    {1'b0, 5'd9,  16'h0000, 16'h0000},
    {1'b0, 5'd31, 16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R12 reset rdata", rdata, 16'h0000);
    chk("R7 reset adv_word", adv_word, 16'h01C1);
    rd(5'd1, v); chk("R1 status reset", v, ST_BASE);
    rd(5'd6, v); chk("R9 exp reset", v, 16'h0000);

    // vector table: ID, advertisement masking, unmapped addresses
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][36:32], v);
        if (VEC[i][36:32] == 5'd2 || VEC[i][36:32] == 5'd3) chk("R5 id", v, VEC[i][15:0]);
        else if (VEC[i][36:32] == 5'd4) chk("R6 adv", v, VEC[i][15:0]);
        else chk("R11 unmapped", v, VEC[i][15:0]);
      end
    end

    // R7: writes did not reach adv_word until restart
    chk("R7 adv_word before restart", adv_word, 16'h01C1);
    @(negedge clk); an_restart = 1'b1;
    @(negedge clk); an_restart = 1'b0;
    chk("R7 adv_word after restart", adv_word, 16'h0001);
    // write and restart in the same cycle
    @(negedge clk); addr = 5'd4; wdata = 16'h2800; wr_en = 1'b1; an_restart = 1'b1;
    @(negedge clk); wr_en = 1'b0; an_restart = 1'b0;
    chk("R7 same-cycle write+restart", adv_word, 16'h0001);
    rd(5'd4, v); chk("R6 adv rf/asym", v, 16'h2801);
    @(negedge clk); an_restart = 1'b1;
    @(negedge clk); an_restart = 1'b0;
    chk("R7 second restart", adv_word, 16'h2801);

    // R1 live bits and write immunity
    an_en = 1'b1; an_comp = 1'b1;
    wr(5'd1, 16'h0000);
    rd(5'd1, v); chk("R1 status an bits", v, ST_BASE | 16'h0028);
    an_en = 1'b0; an_comp = 1'b0;

    // R3 latch-low link
    @(negedge clk); link_ok = 1'b1;
    @(negedge clk);
    rd(5'd1, v); chk("R3 link up", v, ST_BASE | 16'h0004);
    @(negedge clk); link_ok = 1'b0;
    @(negedge clk); link_ok = 1'b1;
    @(negedge clk);
    rd(5'd1, v); chk("R3 link drop latched", v, ST_BASE);
    rd(5'd1, v); chk("R3 link after read", v, ST_BASE | 16'h0004);

    // R2 remote fault
    @(negedge clk); rfault = 1'b1;
    @(negedge clk); rfault = 1'b0;
    repeat (3) @(negedge clk);
    rd(5'd1, v); chk("R2 rfault set", v, ST_BASE | 16'h0014);
    rd(5'd1, v); chk("R2 rfault cleared", v, ST_BASE | 16'h0004);

    // R10 set on the same edge as the clearing read
    @(negedge clk); addr = 5'd1; rd_en = 1'b1; rfault = 1'b1;
    @(negedge clk); rd_en = 1'b0; rfault = 1'b0;
    chk("R10 read returns old", rdata, ST_BASE | 16'h0004);
    rd(5'd1, v); chk("R10 bit kept", v, ST_BASE | 16'h0014);

    // R4 jabber gated by 10 Mb/s mode
    @(negedge clk); speed_10 = 1'b0; jabber = 1'b1;
    @(negedge clk); jabber = 1'b0;
    rd(5'd1, v); chk("R4 jabber ignored at 100", v, ST_BASE | 16'h0004);
    @(negedge clk); speed_10 = 1'b1; jabber = 1'b1;
    @(negedge clk); jabber = 1'b0;
    rd(5'd1, v); chk("R4 jabber set", v, ST_BASE | 16'h0006);
    rd(5'd1, v); chk("R4 jabber cleared", v, ST_BASE | 16'h0004);

    // R8 / R9 link partner and expansion
    @(negedge clk); lp_word = 16'hABCD; lp_valid = 1'b1;
    @(negedge clk); lp_valid = 1'b0; lp_word = 16'h1234;
    wr(5'd5, 16'hFFFF);
    rd(5'd5, v); chk("R8 lp word", v, 16'hABCD);
    rd(5'd6, v); chk("R9 page received", v, 16'h0002);
    rd(5'd6, v); chk("R9 exp cleared", v, 16'h0000);
    @(negedge clk); pd_fault = 1'b1;
    @(negedge clk); pd_fault = 1'b0;
    rd(5'd6, v); chk("R9 pd fault", v, 16'h0010);

    // R10 on expansion
    @(negedge clk); addr = 5'd6; rd_en = 1'b1; lp_valid = 1'b1;
    @(negedge clk); rd_en = 1'b0; lp_valid = 1'b0;
    chk("R10 exp read returns old", rdata, 16'h0000);
    rd(5'd6, v); chk("R10 exp bit kept", v, 16'h0002);

    // R12 rdata holds without a read strobe
    @(negedge clk); pd_fault = 1'b1; addr = 5'd6;
    @(negedge clk); pd_fault = 1'b0;
    @(negedge clk);
    chk("R12 rdata hold", rdata, 16'h0002);
    rd(5'd6, v); chk("R12 rdata after read", v, 16'h0010);

    finish_run();
  end
endmodule